// File: doc/BRIEF.md
# Write-Protection Command Sequencer

This block sits in front of the page-write logic of a byte-wide nonvolatile memory and decides, strobe by strobe, whether an incoming write may reach it. It keeps a protection flag. While the flag is clear, ordinary writes pass. While the flag is set, a write passes only after a three-byte command prefix has been entered. That prefix also sets the flag. A six-byte command clears the flag again, and none of its bytes are ever passed on. The aim is to keep stray strobes, for example from supply noise or a runaway processor, from programming the array.

Each write is presented for one clock cycle on `wr_stb` together with its address and data. The pass decision `wr_pass` is combinational in that same cycle. The protection flag and the sequence step update on the clock edge that ends the cycle. A completed enable prefix opens a permission window. Every write passes until the page logic pulses `prog_start` to start the program cycle, and that pulse closes the window. The command codes and key addresses are parameters. Their defaults are listed below.

Top module: `wp_guard`

## Requirements
- R1: After reset, `prot_on` equals the parameter `PROT_INIT` (default 0), `seq_busy` is 0, and `wr_pass` is 0.
- R2: `wr_pass` is 0 in every cycle where `wr_stb` is 0.
- R3: With `prot_on` at 0, the permission window closed and no sequence in progress, a write that is not the first command byte (data AAh at address 5555h) passes.
- R4: With `prot_on` at 1 and the permission window closed, a write without a completed enable prefix is blocked, and the write leaves `prot_on` unchanged.
- R5: The enable prefix is three consecutive writes: AAh to 5555h, then 55h to 2AAAh, then A0h to 5555h. None of the three passes. In the cycle after the third, `prot_on` is 1, and the following writes pass.
- R6: A one-cycle pulse on `prog_start` closes the permission window. In protected mode, the next write after that pulse is blocked.
- R7: The disable sequence is six consecutive writes: AAh/5555h, 55h/2AAAh, 80h/5555h, AAh/5555h, 55h/2AAAh, 20h/5555h. None of them passes. In the cycle after the sixth, `prot_on` is 0.
- R8: A write that does not match the next expected byte of a partly entered sequence aborts the sequence and `seq_busy` returns to 0. This write is blocked in protected mode and passes in unprotected mode. The one exception is a mismatching write of AAh to 5555h: it is blocked and starts a new sequence, so `seq_busy` stays 1.
- R9: After each matched command byte that does not complete a sequence, `seq_busy` is 1 in the following cycle. Cycles without a strobe leave `seq_busy` and `prot_on` unchanged.
- R10: While the permission window is open, command bytes are treated as data. They pass and do not advance the sequence, so `seq_busy` stays 0.
- R11: Entering the enable prefix while `prot_on` is 0 sets `prot_on` to 1 and opens the permission window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| prog_start | input | 1 | Pulse from the page logic when the program cycle starts; closes the permission window |
| wr_pass | output | 1 | The current write may go to the page-write logic |
| prot_on | output | 1 | Protection flag |
| seq_busy | output | 1 | A command sequence is partly entered |

## Verification
Only three signals carry the internal state to the ports: the step counter, the permission bit and the protection flag. A wrong step shows up on `seq_busy` one cycle after the strobe that caused it. It also shows up in the pass decision of the very next strobe, since a wrongly held step swallows a data write or a wrongly dropped one lets a command byte through. A stale or missing permission bit only appears on the first write after an enable prefix or after `prog_start`. For that reason, the checks write immediately at those points rather than waiting.

// File: rtl/wp_guard.sv
module wp_guard #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter bit PROT_INIT = 1'b0,
  parameter logic [ADDR_W-1:0] KEY_A = 'h5555,
  parameter logic [ADDR_W-1:0] KEY_B = 'h2AAA,
  parameter logic [DATA_W-1:0] D_OPEN1 = 'hAA,
  parameter logic [DATA_W-1:0] D_OPEN2 = 'h55,
  parameter logic [DATA_W-1:0] D_EN = 'hA0,
  parameter logic [DATA_W-1:0] D_DIS1 = 'h80,
  parameter logic [DATA_W-1:0] D_DIS2 = 'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              prog_start,
  output logic              wr_pass,
  output logic              prot_on,
  output logic              seq_busy
);
  localparam int LAST_STEP = 5;
  localparam int STEP_W = $clog2(LAST_STEP + 1);

  logic [STEP_W-1:0] step;
  logic              permit;
  logic              prot_q;
  logic [ADDR_W-1:0] want_addr;
  logic [DATA_W-1:0] want_data;
  logic              hit, hit_alt, restart, armed;

  always_comb begin
    want_addr = KEY_A;
    want_data = D_OPEN1;
    case (step)
      STEP_W'(1), STEP_W'(4): begin want_addr = KEY_B; want_data = D_OPEN2; end
      STEP_W'(2):             want_data = D_EN;
      STEP_W'(5):             want_data = D_DIS2;
      default:                ;
    endcase
  end

  assign armed   = wr_stb && !permit;
  assign hit_alt = (step == STEP_W'(2)) && (wr_addr == KEY_A) && (wr_data == D_DIS1);
  assign hit     = armed && (((wr_addr == want_addr) && (wr_data == want_data)) || hit_alt);
  assign restart = armed && !hit && (wr_addr == KEY_A) && (wr_data == D_OPEN1);

  assign wr_pass  = wr_stb && (permit || (!hit && !restart && !prot_q));
  assign prot_on  = prot_q;
  assign seq_busy = (step != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step   <= '0;
      permit <= 1'b0;
      prot_q <= PROT_INIT;
    end else begin
      if (prog_start) permit <= 1'b0;
      if (hit) begin
        if (step == STEP_W'(2) && !hit_alt) begin
          prot_q <= 1'b1;
          permit <= 1'b1;
          step   <= '0;
        end else if (step == STEP_W'(LAST_STEP)) begin
          prot_q <= 1'b0;
          step   <= '0;
        end else begin
          step <= step + STEP_W'(1);
        end
      end else if (restart) begin
        step <= STEP_W'(1);
      end else if (armed) begin
        step <= '0;
      end
    end
  end
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_A = 'h5555,
  parameter logic [DATA_W-1:0] D_OPEN1 = 'hAA,
  parameter logic [DATA_W-1:0] D_EN = 'hA0,
  parameter logic [DATA_W-1:0] D_DIS2 = 'h20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              prog_start,
  input logic              wr_pass,
  input logic              prot_on,
  input logic              seq_busy
);
  // R2
  no_pass_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> !wr_pass);

  // R5
  prot_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_on) |-> $past(wr_stb && wr_addr == KEY_A && wr_data == D_EN));

  // R7
  prot_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_on) |-> $past(wr_stb && wr_addr == KEY_A && wr_data == D_DIS2));

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(seq_busy) && $stable(prot_on));

  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && seq_busy && prot_on |-> !wr_pass);

  // R3
  open_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && !prot_on && !seq_busy && !(wr_addr == KEY_A && wr_data == D_OPEN1) |-> wr_pass);
endmodule

bind wp_guard wp_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_A(KEY_A),
  .D_OPEN1(D_OPEN1), .D_EN(D_EN), .D_DIS2(D_DIS2)
) u_chk (.*);

// File: tb/wp_guard_bench.sv
module wp_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        prog_start = 1'b0;
  logic        wr_pass, prot_on, seq_busy;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  wp_guard u_wp_guard (.*);

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    #8;
    if (wr_stb) begin
      if (exp_q.size() == 0) check("scoreboard-empty", 1, 0);
      else check(tag_q.pop_front(), int'(wr_pass), int'(exp_q.pop_front()));
    end
  end

  task automatic wr(logic [16:0] a, logic [7:0] d, bit exp, string tag);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    wr_stb = 1'b0;
    #2;
  endtask

  task automatic pulse_prog();
    @(negedge clk); prog_start = 1'b1;
    @(negedge clk); prog_start = 1'b0;
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    check("R1 prot_on", prot_on, 0);
    check("R1 seq_busy", seq_busy, 0);
    check("R1 wr_pass", wr_pass, 0);

    wr(17'h01234, 8'h5A, 1, "R3 plain write open");
    check("R2 idle wr_pass", wr_pass, 0);

    wr(17'h05555, 8'hAA, 0, "R9 step1 held");
    check("R9 busy after 1", seq_busy, 1);
    repeat (2) @(negedge clk);
    check("R9 busy held idle", seq_busy, 1);
    wr(17'h02AAA, 8'h55, 0, "R9 step2 held");
    check("R9 busy after 2", seq_busy, 1);
    wr(17'h00100, 8'h77, 1, "R8 break passes open");
    check("R8 busy cleared", seq_busy, 0);
    check("R8 still open", prot_on, 0);

    wr(17'h05555, 8'hAA, 0, "R11 en1");
    wr(17'h02AAA, 8'h55, 0, "R11 en2");
    wr(17'h05555, 8'hA0, 0, "R11 en3");
    check("R11 prot set", prot_on, 1);
    check("R11 busy idle", seq_busy, 0);
    wr(17'h00010, 8'h11, 1, "R5 permitted write");
    wr(17'h05555, 8'hAA, 1, "R10 cmd byte as data");
    check("R10 no advance", seq_busy, 0);
    wr(17'h02AAA, 8'h55, 1, "R10 cmd byte2 as data");
    check("R10 still idle", seq_busy, 0);

    pulse_prog();
    wr(17'h00020, 8'h33, 0, "R6 blocked after prog");
    check("R4 prot kept", prot_on, 1);
    wr(17'h00021, 8'h34, 0, "R4 blocked again");

    wr(17'h05555, 8'hAA, 0, "R5 en1");
    wr(17'h02AAA, 8'h55, 0, "R5 en2");
    wr(17'h05555, 8'hA0, 0, "R5 en3");
    wr(17'h00030, 8'h44, 1, "R5 write after prefix");
    wr(17'h00031, 8'h45, 1, "R5 second page byte");
    pulse_prog();

    wr(17'h05555, 8'hAA, 0, "R8 p step1");
    wr(17'h02AAA, 8'h11, 0, "R8 break blocked prot");
    check("R8 busy cleared prot", seq_busy, 0);

    wr(17'h05555, 8'hAA, 0, "R8 r1");
    wr(17'h02AAA, 8'h55, 0, "R8 r2");
    wr(17'h05555, 8'hAA, 0, "R8 restart blocked");
    check("R8 restart busy", seq_busy, 1);
    wr(17'h02AAA, 8'h55, 0, "R8 r4");
    wr(17'h05555, 8'hA0, 0, "R8 r5");
    check("R8 restart done", seq_busy, 0);
    wr(17'h00040, 8'h66, 1, "R8 write after restart prefix");
    pulse_prog();

    wr(17'h05555, 8'hAA, 0, "R7 d1");
    wr(17'h02AAA, 8'h55, 0, "R7 d2");
    wr(17'h05555, 8'h80, 0, "R7 d3");
    check("R9 busy mid disable", seq_busy, 1);
    wr(17'h05555, 8'hAA, 0, "R7 d4");
    wr(17'h02AAA, 8'h55, 0, "R7 d5");
    check("R7 prot before last", prot_on, 1);
    wr(17'h05555, 8'h20, 0, "R7 d6");
    check("R7 prot cleared", prot_on, 0);
    check("R7 busy idle", seq_busy, 0);
    wr(17'h00050, 8'h99, 1, "R3 write after disable");

    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    #2;
    check("R1 prot after reset", prot_on, 0);
    check("R1 busy after reset", seq_busy, 0);
    check("scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule